// File: doc/BRIEF.md
# Auxiliary JTAG Test Access Port with Gated Enable

This block is a secondary IEEE 1149.1 test access port controller placed behind a primary JTAG controller. It serves a single debug module. It runs the sixteen-state TAP state machine from TCK and TMS, and shifts TDI to TDO through a 4-bit instruction register or a selected data register.

Only two instruction codes are decoded. Code 0x0 is the enable instruction: it opens the data path to a 32-bit read/write test register. That register stands in for the debug module's register set. Every other code, 0xF included, selects a one-bit bypass register.

The controller is held in reset while power-on reset is high, while censored mode is active, or while the compliance-enable input is low. The primary controller drives that enable to hand the scan chain to this port.

Top module: `aux_tap_ctrl`

## Requirements
- R1: While `por_i` is high, `censor_i` is high or `comp_en_i` is low at a rising TCK edge, the controller enters Test-Logic-Reset at that edge. At the same edge the active instruction becomes 0xF and the test register returns to its reset value (0). `tdo_o` and `tdo_oe_o` are low from the next falling edge. Gated reset overrides any scan in progress.
- R2: The state machine follows the standard sixteen TAP states on rising TCK. Five consecutive rising edges with TMS high reach Test-Logic-Reset from any state. Test-Logic-Reset loads 0xF into the active instruction.
- R3: Capture-IR loads the pattern 4'b0001 into the instruction shift stage. An instruction scan therefore presents 1, 0, 0, 0 on TDO.
- R4: All shifting is least significant bit first. Each rising edge in a Shift state moves TDI into the MSB of the stage and drops its LSB. The first TDO bit of a scan is bit 0 of the captured value.
- R5: With instruction 0x0 active, a data scan goes through the 32-bit test register path. Capture-DR loads the register's current value, so a 32-bit scan returns the previous contents.
- R6: Any instruction other than 0x0 selects the one-bit bypass register. Bypass captures 0, so a 32-bit scan of data D returns {D[30:0],0}. The test register keeps its value.
- R7: The active instruction changes only when the controller is in Update-IR or Test-Logic-Reset. It never changes while the code is being shifted.
- R8: With instruction 0x0 active, `tdr_upd_o` is high for exactly the one TCK cycle spent in Update-DR. The test register takes the shifted value at the rising edge that ends that cycle. Under bypass no strobe appears.
- R9: `tdo_o` and `tdo_oe_o` change only on falling TCK. `tdo_oe_o` is high exactly while the state is Shift-IR or Shift-DR. At all other times `tdo_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| por_i | input | 1 | Power-on reset, active high |
| censor_i | input | 1 | Censored mode, active high, holds the port in reset |
| comp_en_i | input | 1 | Compliance enable from the primary controller, low holds the port in reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| tdo_o | output | 1 | Test data out, falling-edge timed |
| tdo_oe_o | output | 1 | High while `tdo_o` carries scan data |
| tdr_o | output | 32 | Current test register contents |
| tdr_upd_o | output | 1 | One-cycle strobe in Update-DR under instruction 0x0 |

## Verification
The gated reset can fall in the same cycle as a data scan that is still shifting. In that case the reset must win: the partial scan is lost, the test register clears, no update strobe appears and TDO goes quiet. The bench drops the compliance enable partway through a Shift-DR sequence, as a directed case and also through random reset injection between scans. It then checks the test register value and the output enable. After release, a fresh scan must show bypass behaviour, which proves that the instruction fell back to 0xF.

// File: rtl/aux_tap_pkg.sv
package aux_tap_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_ENABLE      = 4'h0;
    localparam logic [IR_W-1:0] OP_BYPASS      = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

    localparam int ONES_TO_RESET = 5;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_DR_SEL,
        TS_DR_CAP,
        TS_DR_SHIFT,
        TS_DR_EX1,
        TS_DR_PAUSE,
        TS_DR_EX2,
        TS_DR_UPD,
        TS_IR_SEL,
        TS_IR_CAP,
        TS_IR_SHIFT,
        TS_IR_EX1,
        TS_IR_PAUSE,
        TS_IR_EX2,
        TS_IR_UPD
    } tap_state_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } scan_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        tap_state_e n;
        case (s)
            TS_RESET:    n = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:     n = tms ? TS_DR_SEL : TS_IDLE;
            TS_DR_SEL:   n = tms ? TS_IR_SEL : TS_DR_CAP;
            TS_DR_CAP:   n = tms ? TS_DR_EX1 : TS_DR_SHIFT;
            TS_DR_SHIFT: n = tms ? TS_DR_EX1 : TS_DR_SHIFT;
            TS_DR_EX1:   n = tms ? TS_DR_UPD : TS_DR_PAUSE;
            TS_DR_PAUSE: n = tms ? TS_DR_EX2 : TS_DR_PAUSE;
            TS_DR_EX2:   n = tms ? TS_DR_UPD : TS_DR_SHIFT;
            TS_DR_UPD:   n = tms ? TS_DR_SEL : TS_IDLE;
            TS_IR_SEL:   n = tms ? TS_RESET  : TS_IR_CAP;
            TS_IR_CAP:   n = tms ? TS_IR_EX1 : TS_IR_SHIFT;
            TS_IR_SHIFT: n = tms ? TS_IR_EX1 : TS_IR_SHIFT;
            TS_IR_EX1:   n = tms ? TS_IR_UPD : TS_IR_PAUSE;
            TS_IR_PAUSE: n = tms ? TS_IR_EX2 : TS_IR_PAUSE;
            TS_IR_EX2:   n = tms ? TS_IR_UPD : TS_IR_SHIFT;
            TS_IR_UPD:   n = tms ? TS_DR_SEL : TS_IDLE;
            default:     n = TS_RESET;
        endcase
        return n;
    endfunction

    function automatic scan_ctl_t dr_ctl(input tap_state_e s);
        scan_ctl_t c;
        c.capture = (s == TS_DR_CAP);
        c.shift   = (s == TS_DR_SHIFT);
        c.update  = (s == TS_DR_UPD);
        return c;
    endfunction

    function automatic scan_ctl_t ir_ctl(input tap_state_e s);
        scan_ctl_t c;
        c.capture = (s == TS_IR_CAP);
        c.shift   = (s == TS_IR_SHIFT);
        c.update  = (s == TS_IR_UPD);
        return c;
    endfunction

    function automatic logic op_is_enable(input logic [IR_W-1:0] op);
        return op == OP_ENABLE;
    endfunction

endpackage

// File: rtl/aux_tap_fsm.sv
module aux_tap_fsm
    import aux_tap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tms_i,
    output tap_state_e state_o
);

    localparam int CNT_W = $clog2(ONES_TO_RESET + 1);

    tap_state_e       state_q;
    logic [CNT_W-1:0] ones_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= TS_RESET;
        end else begin
            state_q <= tap_next(state_q, tms_i);
        end
    end

    // saturating run length of TMS-high edges, used by the checker below
    always_ff @(posedge clk_i) begin
        if (rst_i || !tms_i) begin
            ones_q <= '0;
        end else if (ones_q != CNT_W'(ONES_TO_RESET)) begin
            ones_q <= ones_q + 1'b1;
        end
    end

    assign state_o = state_q;

    // R2: five TMS-high edges always land in Test-Logic-Reset
    assert_tlr_after_ones_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (ones_q == CNT_W'(ONES_TO_RESET)) |-> (state_q == TS_RESET));

endmodule

// File: rtl/aux_tap_ir.sv
module aux_tap_ir
    import aux_tap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  tap_state_e state_i,
    input  logic       tdi_i,
    output logic       so_o,
    output logic       enable_o
);

    scan_ctl_t       ctl;
    logic [IR_W-1:0] stage_q;
    logic [IR_W-1:0] active_q;

    assign ctl = ir_ctl(state_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= OP_BYPASS;
        end else if (ctl.capture) begin
            stage_q <= IR_CAPTURE_PAT;
        end else if (ctl.shift) begin
            stage_q <= {tdi_i, stage_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || state_i == TS_RESET) begin
            active_q <= OP_BYPASS;
        end else if (ctl.update) begin
            active_q <= stage_q;
        end
    end

    assign so_o     = stage_q[0];
    assign enable_o = op_is_enable(active_q);

    // R3: capture pattern present right after Capture-IR
    assert_capir_pattern_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(state_i) == TS_IR_CAP) |-> (stage_q == IR_CAPTURE_PAT));

    // R7: the instruction only moves after Update-IR or Test-Logic-Reset
    assert_ir_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !($past(state_i) == TS_IR_UPD || $past(state_i) == TS_RESET) |-> $stable(active_q));

    // R2: Test-Logic-Reset leaves the bypass code active
    assert_tlr_bypass_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(state_i) == TS_RESET) |-> (active_q == OP_BYPASS));

endmodule

// File: rtl/aux_tap_dr.sv
module aux_tap_dr
    import aux_tap_pkg::*;
#(
    parameter int               TDR_W   = 32,
    parameter logic [TDR_W-1:0] TDR_RST = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  tap_state_e       state_i,
    input  logic             tdi_i,
    input  logic             enable_i,
    output logic             so_o,
    output logic [TDR_W-1:0] tdr_o,
    output logic             upd_o
);

    scan_ctl_t        ctl;
    logic [TDR_W-1:0] sr_q;
    logic [TDR_W-1:0] tdr_q;
    logic             byp_q;

    assign ctl = dr_ctl(state_i);

    // test register scan stage
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sr_q <= '0;
        end else if (enable_i) begin
            if (ctl.capture) begin
                sr_q <= tdr_q;
            end else if (ctl.shift) begin
                sr_q <= {tdi_i, sr_q[TDR_W-1:1]};
            end
        end
    end

    // bypass bit: captures zero, one stage deep
    always_ff @(posedge clk_i) begin
        if (rst_i || ctl.capture) begin
            byp_q <= 1'b0;
        end else if (ctl.shift && !enable_i) begin
            byp_q <= tdi_i;
        end
    end

    // parallel test register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tdr_q <= TDR_RST;
        end else if (ctl.update && enable_i) begin
            tdr_q <= sr_q;
        end
    end

    assign so_o  = enable_i ? sr_q[0] : byp_q;
    assign tdr_o = tdr_q;
    assign upd_o = ctl.update && enable_i;

    // R6: bypass bit is zero right after Capture-DR
    assert_byp_capture_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(state_i) == TS_DR_CAP) |-> (byp_q == 1'b0));

    // R8: strobe never lasts two cycles
    assert_upd_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        upd_o |=> !upd_o);

    // R8: register moves only on the edge that closes a strobe cycle
    assert_tdr_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(upd_o) |-> $stable(tdr_q));

endmodule

// File: rtl/aux_tap_ctrl.sv
module aux_tap_ctrl
    import aux_tap_pkg::*;
#(
    parameter int               TDR_W   = 32,
    parameter logic [TDR_W-1:0] TDR_RST = '0
) (
    input  logic             tck_i,
    input  logic             por_i,
    input  logic             censor_i,
    input  logic             comp_en_i,
    input  logic             tms_i,
    input  logic             tdi_i,
    output logic             tdo_o,
    output logic             tdo_oe_o,
    output logic [TDR_W-1:0] tdr_o,
    output logic             tdr_upd_o
);

    logic       rst;
    tap_state_e state;
    logic       ir_so;
    logic       dr_so;
    logic       enable;
    logic       tdo_q;
    logic       oe_q;

    // R1: any of the three conditions holds the port in reset
    assign rst = por_i || censor_i || !comp_en_i;

    aux_tap_fsm u_fsm (
        .clk_i   (tck_i),
        .rst_i   (rst),
        .tms_i   (tms_i),
        .state_o (state)
    );

    aux_tap_ir u_ir (
        .clk_i    (tck_i),
        .rst_i    (rst),
        .state_i  (state),
        .tdi_i    (tdi_i),
        .so_o     (ir_so),
        .enable_o (enable)
    );

    aux_tap_dr #(
        .TDR_W   (TDR_W),
        .TDR_RST (TDR_RST)
    ) u_dr (
        .clk_i    (tck_i),
        .rst_i    (rst),
        .state_i  (state),
        .tdi_i    (tdi_i),
        .enable_i (enable),
        .so_o     (dr_so),
        .tdr_o    (tdr_o),
        .upd_o    (tdr_upd_o)
    );

    // R9: output stage retimed to the falling edge
    always_ff @(negedge tck_i) begin
        if (rst) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (state == TS_IR_SHIFT) begin
            tdo_q <= ir_so;
            oe_q  <= 1'b1;
        end else if (state == TS_DR_SHIFT) begin
            tdo_q <= dr_so;
            oe_q  <= 1'b1;
        end else begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end
    end

    assign tdo_o    = tdo_q;
    assign tdo_oe_o = oe_q;

    // R1: a rising edge under gated reset leaves the state machine in reset
    assert_gated_reset_R1: assert property (@(posedge tck_i)
        $past(rst) && !rst |-> (state == TS_RESET));

endmodule

// File: tb/aux_tap_ctrl_bench.sv
module aux_tap_ctrl_bench;

    logic        tck = 1'b0;
    logic        por, censor, comp_en, tms, tdi;
    logic        tdo, oe, upd;
    logic [31:0] tdr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0]  model_ir;
    logic [31:0] model_tdr;
    logic        s_tdo, s_oe, s_upd;
    logic [31:0] s_tdr;

    always #5 tck = ~tck;

    aux_tap_ctrl u_aux_tap_ctrl (
        .tck_i     (tck),
        .por_i     (por),
        .censor_i  (censor),
        .comp_en_i (comp_en),
        .tms_i     (tms),
        .tdi_i     (tdi),
        .tdo_o     (tdo),
        .tdo_oe_o  (oe),
        .tdr_o     (tdr),
        .tdr_upd_o (upd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_scan(input logic [3:0] ir, input logic [31:0] cur,
                                             input logic [31:0] din);
        return (ir == 4'h0) ? cur : {din[30:0], 1'b0};
    endfunction

    // sample what the current state presents, then drive the next edge's inputs
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        s_tdo = tdo; s_oe = oe; s_upd = upd; s_tdr = tdr;
        tms = m; tdi = d;
    endtask

    task automatic scan_ir(input logic [3:0] op);
        logic [3:0] cap;
        logic       oe_all;
        oe_all = 1'b1;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, op[i]);
            cap[i] = s_tdo;
            oe_all &= s_oe;
        end
        chk("R3 capture pattern", {28'd0, cap}, 32'h1);
        chk("R9 oe during shift-ir", {31'd0, oe_all}, 32'h1);
        step(1, 0);
        chk("R9 tdo/oe quiet in exit1-ir", {30'd0, s_tdo, s_oe}, 32'h0);
        step(0, 0);
        model_ir = op;
    endtask

    task automatic scan_dr(input logic [31:0] din, input string req);
        logic [31:0] dout;
        logic        en;
        en = (model_ir == 4'h0);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 32; i++) begin
            step(i == 31, din[i]);
            dout[i] = s_tdo;
        end
        chk({req, " scan out (R4 lsb first)"}, dout, exp_scan(model_ir, model_tdr, din));
        step(1, 0);
        chk("R9 tdo/oe quiet in exit1-dr", {30'd0, s_tdo, s_oe}, 32'h0);
        step(0, 0);
        chk("R8 update strobe", {31'd0, s_upd}, {31'd0, en});
        step(0, 0);
        chk("R8 strobe gone after update", {31'd0, s_upd}, 32'h0);
        if (en) model_tdr = din;
        chk({req, " test register"}, s_tdr, model_tdr);
    endtask

    task automatic apply_reset(input int kind);
        @(negedge tck);
        case (kind)
            0:       por = 1'b1;
            1:       censor = 1'b1;
            default: comp_en = 1'b0;
        endcase
        tms = 1'b0;
        repeat (3) @(negedge tck);
        #1;
        chk("R1 test register cleared", tdr, 32'h0);
        chk("R1 tdo/oe low in reset", {30'd0, tdo, oe}, 32'h0);
        por = 1'b0; censor = 1'b0; comp_en = 1'b1;
        model_ir  = 4'hF;
        model_tdr = 32'h0;
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        por = 1'b1; censor = 1'b0; comp_en = 1'b1; tms = 1'b1; tdi = 1'b0;
        model_ir = 4'hF; model_tdr = 32'h0;
        repeat (4) @(negedge tck);
        #1;
        chk("R1 reset test register", tdr, 32'h0);
        chk("R1 reset tdo/oe", {30'd0, tdo, oe}, 32'h0);
        chk("R1 reset strobe", {31'd0, upd}, 32'h0);
        por = 1'b0; tms = 1'b0;

        // bypass is the instruction after reset
        scan_dr(32'hDEAD_BEEF, "R6 bypass after reset");

        // enable instruction
        scan_ir(4'h0);
        scan_dr(32'hA5A5_1234, "R5 enable first");
        scan_dr(32'h0F0F_8001, "R5 enable readback");

        // explicit bypass and an unimplemented code
        scan_ir(4'hF);
        scan_dr(32'h8000_0001, "R6 bypass 0xF");
        scan_ir(4'h5);
        scan_dr(32'h1234_5678, "R6 unimplemented 0x5");

        // re-select enable only through Update-IR
        scan_ir(4'h0);
        scan_dr(32'h7777_AAAA, "R7 enable after update-ir");

        // five TMS-high edges back to reset, instruction returns to bypass
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        model_ir = 4'hF;
        scan_dr(32'h0000_FFFF, "R2 tms reset gives bypass");

        // gated reset lands in the middle of a data scan
        scan_ir(4'h0);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 10; i++) step(0, 1);
        @(negedge tck);
        comp_en = 1'b0;
        @(negedge tck);
        @(negedge tck);
        #1;
        chk("R1 mid-scan reset clears register", tdr, 32'h0);
        chk("R1 mid-scan reset tdo/oe", {30'd0, tdo, oe}, 32'h0);
        chk("R1 mid-scan reset no strobe", {31'd0, upd}, 32'h0);
        comp_en = 1'b1; tms = 1'b0;
        model_ir = 4'hF; model_tdr = 32'h0;
        scan_dr(32'hCAFE_0001, "R1 bypass after mid-scan reset");

        // constrained random mix
        for (int n = 0; n < 40; n++) begin
            int r;
            r = $urandom % 8;
            if (r == 0) begin
                apply_reset($urandom % 3);
            end else begin
                logic [3:0] op;
                case ($urandom % 3)
                    0:       op = 4'h0;
                    1:       op = 4'hF;
                    default: op = 4'($urandom);
                endcase
                scan_ir(op);
                scan_dr($urandom, (op == 4'h0) ? "R5 random enable" : "R6 random bypass");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule